// File: doc/BRIEF.md
# Timer Synchronization Pulse Unit

This unit sits beside a group of six timers, one master and five slaves labelled A to E. It does two jobs. First, it turns one selected timer event into a synchronization pulse on a single output pin. A 2-bit source field picks the event, and a 2-bit mode field either disables the pin or makes it drive a fixed 16-cycle pulse of either polarity. Second, it holds the six counter-enable bits. It can also start the master counter when an event arrives on the sync input.

Software reaches the unit through two write strobes, one for the configuration fields and one for the enable bits. The unit applies two safety rules in hardware. A write to the mode field is dropped while any counter is running. A request to flip an enable bit is dropped for that bit if it comes fewer than 8 cycles after that bit last changed. The timers' own counting and compare logic sits outside this block. They only supply event strobes and take the enable bits and the master restart strobe.

Top module: `tsync_unit`

## Requirements
- R1: After a synchronous active-low reset, all six enable bits read 0, `mst_restart` is 0 and `sync_out` is 0. The mode field is disabled (00), the source field is 00 and start-on-sync is off.
- R2: The source field selects the trigger event: 00 = `ev_mst_start`, 01 = `ev_mst_cmp1`, 10 = `ev_ta_start`, 11 = `ev_ta_cmp1`. The three unselected strobes never start a pulse.
- R3: In mode 10 (positive), `sync_out` idles at 0. A selected event sampled at a clock edge drives it to 1 from that edge for exactly 16 cycles.
- R4: In mode 11 (negative), `sync_out` idles at 1. A selected event drives it to 0 from that edge for exactly 16 cycles.
- R5: In mode 00 (disabled) and mode 01 (reserved), `sync_out` stays 0 and trigger events have no effect on it.
- R6: A selected event that arrives while a pulse is active restarts the 16-cycle count. The result is one longer pulse that ends 16 cycles after the latest event.
- R7: With start-on-sync set, a `sync_in` strobe causes two things one cycle later: a one-cycle `mst_restart` pulse, and `cnt_en[0]` set to 1. Each strobe gives its own restart, even when the master is already enabled, and strobes are never queued.
- R8: With start-on-sync clear, `sync_in` has no effect on `mst_restart` or `cnt_en[0]`.
- R9: On `en_wr`, each bit of `cnt_en` takes the value of the same bit of `en_wdata` one cycle later. Bit 0 is the master and bits 1 to 5 are timers A to E.
- R10: A request that would change an enable bit fewer than 8 cycles after that bit's previous change is ignored for that bit only. A request made exactly 8 cycles after the change is accepted.
- R11: A `cfg_wr` leaves the mode field unchanged while any `cnt_en` bit is 1. The source and start-on-sync fields of the same write are still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Trigger source to write |
| cfg_mode | input | 2 | Output mode to write |
| cfg_start_on_sync | input | 1 | Start-on-sync enable to write |
| en_wr | input | 1 | Enable-bit write strobe |
| en_wdata | input | NUM_TMR | Requested enable bits (bit 0 master, 1..5 A..E) |
| ev_mst_start | input | 1 | Master timer start strobe |
| ev_mst_cmp1 | input | 1 | Master compare 1 strobe |
| ev_ta_start | input | 1 | Timer A start/reset strobe |
| ev_ta_cmp1 | input | 1 | Timer A compare 1 strobe |
| sync_in | input | 1 | Synchronization input event strobe |
| cnt_en | output | NUM_TMR | Counter-enable bits |
| mst_restart | output | 1 | One-cycle master counter start/restart |
| sync_out | output | 1 | Synchronization output pin |

## Verification
The bench probes the last active cycle of a pulse and the first idle cycle after it. A stretcher that is off by one would show a 15- or 17-cycle pulse there. It retriggers in the middle of a pulse, which catches a design that drops the second event or produces a double pulse. It also checks a change request 7 cycles after the previous change and another 8 cycles after it. A guard window of the wrong length would accept the first or reject the second. Further cases cover a mode write while a counter runs, back-to-back sync strobes, and every non-selected source. These expose a mode that leaks through, a queued or merged master restart, and a wrong source decode.

// File: rtl/tsync_pkg.sv
// Shared types for the timer synchronization pulse unit.
package tsync_pkg;
    localparam int TMR_COUNT = 6;

    typedef enum logic [1:0] {
        SRC_MST_START = 2'b00,
        SRC_MST_CMP1  = 2'b01,
        SRC_TA_START  = 2'b10,
        SRC_TA_CMP1   = 2'b11
    } sync_src_e;

    typedef enum logic [1:0] {
        OUT_OFF  = 2'b00,
        OUT_RSVD = 2'b01,
        OUT_POS  = 2'b10,
        OUT_NEG  = 2'b11
    } sync_mode_e;

    typedef struct packed {
        sync_src_e  src;
        sync_mode_e mode;
        logic       start_on_sync;
    } sync_cfg_t;
endpackage

// File: rtl/tsync_cfg.sv
// Configuration register for the sync unit.
// Holds source, output mode and start-on-sync. The mode field is frozen
// while lock is high; the other fields always take a write.
// Assumes single-cycle write strobes.
module tsync_cfg
    import tsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  sync_src_e  wr_src,
    input  sync_mode_e wr_mode,
    input  logic       wr_start_on_sync,
    input  logic       lock,
    output sync_cfg_t  cfg_q
);
    // Capture configuration writes; drop mode while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{src: SRC_MST_START, mode: OUT_OFF, start_on_sync: 1'b0};
        end else if (wr) begin
            cfg_q.src           <= wr_src;
            cfg_q.start_on_sync <= wr_start_on_sync;
            if (!lock) begin
                cfg_q.mode <= wr_mode;
            end
        end
    end
endmodule

// File: rtl/tsync_enables.sv
// Counter-enable bank with per-bit change guard.
// Each bit follows the write data, but a change is refused while that
// bit's guard counter runs (GUARD_CYC cycles after its last change).
// A force_set request sets a bit regardless of the guard.
// Assumes GUARD_CYC >= 1.
module tsync_enables #(
    parameter int NUM_TMR   = 6,
    parameter int GUARD_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [NUM_TMR-1:0] wdata,
    input  logic [NUM_TMR-1:0] force_set,
    output logic [NUM_TMR-1:0] en
);
    localparam int GW = $clog2(GUARD_CYC + 1);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_bit
        logic          bit_q;
        logic [GW-1:0] guard_q;
        logic          want;
        logic          change;

        // Work out the requested value and whether it may be applied.
        always_comb begin
            if (force_set[i]) begin
                want = 1'b1;
            end else if (wr) begin
                want = wdata[i];
            end else begin
                want = bit_q;
            end
            change = (want != bit_q) && (force_set[i] || (guard_q == '0));
        end

        // Update the bit and restart or run down its guard window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q   <= 1'b0;
                guard_q <= '0;
            end else if (change) begin
                bit_q   <= want;
                guard_q <= GW'(GUARD_CYC - 1);
            end else if (guard_q != '0) begin
                guard_q <= guard_q - 1'b1;
            end
        end

        assign en[i] = bit_q;
    end
endmodule

// File: rtl/tsync_pulse.sv
// Sync output pulse generator.
// Picks one of four timer event strobes, and in the pulse modes stretches
// it to PULSE_LEN cycles, retriggering on a fresh event. The pin level
// follows the mode: active-high, active-low or held at 0.
// Assumes event strobes are synchronous to clk.
module tsync_pulse
    import tsync_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  sync_src_e  src,
    input  sync_mode_e mode,
    input  logic       ev_mst_start,
    input  logic       ev_mst_cmp1,
    input  logic       ev_ta_start,
    input  logic       ev_ta_cmp1,
    output logic       sync_out
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic          sel_ev;
    logic          fire;
    logic          active;
    logic [CW-1:0] cnt_q;

    // Choose the trigger event named by the source field.
    always_comb begin
        unique case (src)
            SRC_MST_START: sel_ev = ev_mst_start;
            SRC_MST_CMP1:  sel_ev = ev_mst_cmp1;
            SRC_TA_START:  sel_ev = ev_ta_start;
            SRC_TA_CMP1:   sel_ev = ev_ta_cmp1;
            default:       sel_ev = 1'b0;
        endcase
    end

    assign fire = sel_ev && (mode == OUT_POS || mode == OUT_NEG);

    // Load the stretch counter on an event, else run it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= CW'(PULSE_LEN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);

    // Drive the pin level for the current mode.
    always_comb begin
        unique case (mode)
            OUT_POS: sync_out = active;
            OUT_NEG: sync_out = ~active;
            default: sync_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsync_unit.sv
// Timer synchronization pulse unit (top).
// Ties the configuration register, the counter-enable bank and the
// output pulse generator together. It also turns sync input events into
// master restarts when start-on-sync is set.
// Assumes all strobes are single-cycle and synchronous to clk.
module tsync_unit
    import tsync_pkg::*;
#(
    parameter int NUM_TMR   = TMR_COUNT,
    parameter int PULSE_LEN = 16,
    parameter int GUARD_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_src,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_start_on_sync,
    input  logic               en_wr,
    input  logic [NUM_TMR-1:0] en_wdata,
    input  logic               ev_mst_start,
    input  logic               ev_mst_cmp1,
    input  logic               ev_ta_start,
    input  logic               ev_ta_cmp1,
    input  logic               sync_in,
    output logic [NUM_TMR-1:0] cnt_en,
    output logic               mst_restart,
    output logic               sync_out
);
    sync_cfg_t          cfg_q;
    logic               any_en;
    logic               sync_go;
    logic [NUM_TMR-1:0] force_set;
    logic               restart_q;
    logic [1:0]         cur_mode;
    logic [1:0]         cur_src;
    logic               cur_sso;

    assign any_en    = |cnt_en;
    assign sync_go   = cfg_q.start_on_sync & sync_in;
    assign force_set = {{(NUM_TMR-1){1'b0}}, sync_go};
    assign cur_mode  = cfg_q.mode;
    assign cur_src   = cfg_q.src;
    assign cur_sso   = cfg_q.start_on_sync;

    tsync_cfg u_cfg (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr               (cfg_wr),
        .wr_src           (sync_src_e'(cfg_src)),
        .wr_mode          (sync_mode_e'(cfg_mode)),
        .wr_start_on_sync (cfg_start_on_sync),
        .lock             (any_en),
        .cfg_q            (cfg_q)
    );

    tsync_enables #(
        .NUM_TMR   (NUM_TMR),
        .GUARD_CYC (GUARD_CYC)
    ) u_enables (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (en_wr),
        .wdata     (en_wdata),
        .force_set (force_set),
        .en        (cnt_en)
    );

    tsync_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk          (clk),
        .rst_n        (rst_n),
        .src          (cfg_q.src),
        .mode         (cfg_q.mode),
        .ev_mst_start (ev_mst_start),
        .ev_mst_cmp1  (ev_mst_cmp1),
        .ev_ta_start  (ev_ta_start),
        .ev_ta_cmp1   (ev_ta_cmp1),
        .sync_out     (sync_out)
    );

    // Register one master restart strobe per accepted sync input event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
        end else begin
            restart_q <= sync_go;
        end
    end

    assign mst_restart = restart_q;
endmodule

// File: rtl/tsync_unit_chk.sv
// Property checker for tsync_unit, attached with bind below.
// Recomputes the selected event from the ports and tracks per-bit
// change age with its own counters.
module tsync_unit_chk #(
    parameter int NUM_TMR   = 6,
    parameter int GUARD_CYC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr,
    input logic               ev_mst_start,
    input logic               ev_mst_cmp1,
    input logic               ev_ta_start,
    input logic               ev_ta_cmp1,
    input logic               sync_in,
    input logic [NUM_TMR-1:0] cnt_en,
    input logic               mst_restart,
    input logic               sync_out,
    input logic [1:0]         cur_mode,
    input logic [1:0]         cur_src,
    input logic               cur_sso
);
    localparam int AW = $clog2(GUARD_CYC + 1);

    logic ev_pick;
    assign ev_pick = (cur_src == 2'b00) ? ev_mst_start :
                     (cur_src == 2'b01) ? ev_mst_cmp1  :
                     (cur_src == 2'b10) ? ev_ta_start  : ev_ta_cmp1;

    // R3: a selected event in positive mode raises the pin next cycle
    p_pos_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pick && cur_mode == 2'b10 && !cfg_wr) |=> sync_out);

    // R4: a selected event in negative mode lowers the pin next cycle
    p_neg_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pick && cur_mode == 2'b11 && !cfg_wr) |=> !sync_out);

    // R5: disabled and reserved modes keep the pin low
    p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_mode[1] && !cfg_wr) |=> !sync_out);

    // R7: accepted sync input gives a restart and an enabled master
    p_sync_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sso && sync_in) |=> (mst_restart && cnt_en[0]));

    // R8: no restart without an accepted sync input
    p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_sso && sync_in) |=> !mst_restart);

    // R11: mode field holds while any counter runs
    p_mode_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|cnt_en) |=> $stable(cur_mode));

    // R10: timer enable bits never change twice inside the guard window
    for (genvar i = 1; i < NUM_TMR; i++) begin : g_age
        logic          prev_q;
        logic [AW-1:0] age_q;
        logic          moved;

        assign moved = (cnt_en[i] != prev_q);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                age_q  <= AW'(GUARD_CYC);
            end else begin
                prev_q <= cnt_en[i];
                if (moved) begin
                    age_q <= AW'(1);
                end else if (age_q < AW'(GUARD_CYC)) begin
                    age_q <= age_q + 1'b1;
                end
            end
        end

        p_guard_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
            moved |-> (age_q >= AW'(GUARD_CYC)));
    end
endmodule

bind tsync_unit tsync_unit_chk #(
    .NUM_TMR   (NUM_TMR),
    .GUARD_CYC (GUARD_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .ev_mst_start (ev_mst_start),
    .ev_mst_cmp1  (ev_mst_cmp1),
    .ev_ta_start  (ev_ta_start),
    .ev_ta_cmp1   (ev_ta_cmp1),
    .sync_in      (sync_in),
    .cnt_en       (cnt_en),
    .mst_restart  (mst_restart),
    .sync_out     (sync_out),
    .cur_mode     (cur_mode),
    .cur_src      (cur_src),
    .cur_sso      (cur_sso)
);

// File: tb/tsync_unit_bench.sv
// Bench for tsync_unit: behavioural reference model compared every clock,
// plus directed checks tagged by requirement.
module tsync_unit_bench;
    localparam int N    = 6;
    localparam int PLEN = 16;
    localparam int GRD  = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [1:0]   cfg_src = 2'b00;
    logic [1:0]   cfg_mode = 2'b00;
    logic         cfg_start_on_sync = 1'b0;
    logic         en_wr = 1'b0;
    logic [N-1:0] en_wdata = '0;
    logic         ev_ms = 1'b0, ev_mc = 1'b0, ev_as = 1'b0, ev_ac = 1'b0;
    logic         sync_in = 1'b0;
    logic [N-1:0] cnt_en;
    logic         mst_restart;
    logic         sync_out;

    always #4 clk = ~clk;

    tsync_unit u_tsync_unit (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_wr            (cfg_wr),
        .cfg_src           (cfg_src),
        .cfg_mode          (cfg_mode),
        .cfg_start_on_sync (cfg_start_on_sync),
        .en_wr             (en_wr),
        .en_wdata          (en_wdata),
        .ev_mst_start      (ev_ms),
        .ev_mst_cmp1       (ev_mc),
        .ev_ta_start       (ev_as),
        .ev_ta_cmp1        (ev_ac),
        .sync_in           (sync_in),
        .cnt_en            (cnt_en),
        .mst_restart       (mst_restart),
        .sync_out          (sync_out)
    );

    int    total = 0;
    int    bad   = 0;
    string phase = "R1";
    bit    live  = 1'b0;

    // Reference model state
    int m_mode, m_src, m_sso, m_cnt, m_rst;
    int m_en  [N];
    int m_age [N];

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Reference model: advances on every rising edge from the requirements.
    always @(posedge clk) begin : model
        int  sel;
        int  want;
        int  anyen;
        bit  frc;
        if (!rst_n) begin
            m_mode = 0; m_src = 0; m_sso = 0; m_cnt = 0; m_rst = 0;
            for (int i = 0; i < N; i++) begin m_en[i] = 0; m_age[i] = GRD; end
            live = 1'b1;
        end else begin
            case (m_src)
                0:       sel = int'(ev_ms);
                1:       sel = int'(ev_mc);
                2:       sel = int'(ev_as);
                default: sel = int'(ev_ac);
            endcase
            anyen = 0;
            for (int i = 0; i < N; i++) if (m_en[i] != 0) anyen = 1;
            if (m_mode >= 2 && sel != 0) m_cnt = PLEN;
            else if (m_cnt > 0) m_cnt--;
            m_rst = (m_sso != 0 && sync_in) ? 1 : 0;
            for (int i = 0; i < N; i++) begin
                if (m_age[i] < GRD) m_age[i]++;
                want = en_wr ? int'(en_wdata[i]) : m_en[i];
                frc  = (i == 0) && (m_sso != 0) && sync_in;
                if (frc) want = 1;
                if (want != m_en[i] && (frc || m_age[i] >= GRD)) begin
                    m_en[i]  = want;
                    m_age[i] = 0;
                end
            end
            if (cfg_wr) begin
                m_src = int'(cfg_src);
                m_sso = int'(cfg_start_on_sync);
                if (anyen == 0) m_mode = int'(cfg_mode);
            end
        end
    end

    // Compare the design to the model away from the active edge.
    always @(negedge clk) begin : compare
        int exp_out;
        int exp_en;
        if (live) begin
            exp_out = (m_mode == 2) ? int'(m_cnt > 0) :
                      (m_mode == 3) ? int'(m_cnt == 0) : 0;
            exp_en = 0;
            for (int i = 0; i < N; i++) exp_en |= (m_en[i] << i);
            chk({phase, " model sync_out"}, int'(sync_out), exp_out);
            chk({phase, " model cnt_en"}, int'(cnt_en), exp_en);
            chk({phase, " model mst_restart"}, int'(mst_restart), m_rst);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(int s, int m, int y);
        cfg_wr = 1'b1; cfg_src = 2'(s); cfg_mode = 2'(m); cfg_start_on_sync = 1'(y);
        tick(1);
        cfg_wr = 1'b0;
    endtask

    task automatic enw(int d);
        en_wr = 1'b1; en_wdata = N'(d);
        tick(1);
        en_wr = 1'b0;
    endtask

    task automatic ev(int k);
        ev_ms = (k == 0); ev_mc = (k == 1); ev_as = (k == 2); ev_ac = (k == 3);
        tick(1);
        ev_ms = 1'b0; ev_mc = 1'b0; ev_as = 1'b0; ev_ac = 1'b0;
    endtask

    task automatic pulse_sync();
        sync_in = 1'b1;
        tick(1);
        sync_in = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        phase = "R1";
        chk("R1 cnt_en", int'(cnt_en), 0);
        chk("R1 sync_out", int'(sync_out), 0);
        chk("R1 mst_restart", int'(mst_restart), 0);

        // R5: disabled and reserved modes ignore events
        phase = "R5";
        ev(0);
        chk("R5 off mode", int'(sync_out), 0);
        cfg(0, 1, 0);
        ev(0);
        chk("R5 reserved mode", int'(sync_out), 0);
        tick(3);
        chk("R5 reserved later", int'(sync_out), 0);

        // R3: positive pulse length
        phase = "R3";
        cfg(0, 2, 0);
        chk("R3 idle", int'(sync_out), 0);
        ev(0);
        chk("R3 first cycle", int'(sync_out), 1);
        tick(15);
        chk("R3 sixteenth cycle", int'(sync_out), 1);
        tick(1);
        chk("R3 after end", int'(sync_out), 0);

        // R2: source decode, unselected strobes ignored
        phase = "R2";
        for (int s = 0; s < 4; s++) begin
            cfg(s, 2, 0);
            tick(20);
            for (int k = 0; k < 4; k++) begin
                if (k != s) begin
                    ev(k);
                    chk($sformatf("R2 src%0d ignores ev%0d", s, k), int'(sync_out), 0);
                end
            end
            ev(s);
            chk($sformatf("R2 src%0d fires", s), int'(sync_out), 1);
            tick(20);
        end

        // R6: retrigger extends into one pulse
        phase = "R6";
        cfg(0, 2, 0);
        ev(0);
        tick(9);
        ev(0);
        tick(15);
        chk("R6 extended", int'(sync_out), 1);
        tick(1);
        chk("R6 ends", int'(sync_out), 0);

        // R4: negative pulse
        phase = "R4";
        cfg(0, 3, 0);
        chk("R4 idle high", int'(sync_out), 1);
        ev(0);
        chk("R4 low start", int'(sync_out), 0);
        tick(15);
        chk("R4 low end", int'(sync_out), 0);
        tick(1);
        chk("R4 back high", int'(sync_out), 1);

        // R11: mode locked while a counter runs
        phase = "R11";
        enw(6'b000100);
        chk("R9 write bit2", int'(cnt_en), 6'b000100);
        cfg(0, 2, 0);
        chk("R11 mode kept negative", int'(sync_out), 1);
        ev(0);
        chk("R11 still negative pulse", int'(sync_out), 0);
        tick(20);
        enw(0);
        chk("R11 cleared", int'(cnt_en), 0);
        cfg(0, 2, 0);
        chk("R11 mode taken when idle", int'(sync_out), 0);
        ev(0);
        chk("R11 positive pulse", int'(sync_out), 1);
        tick(20);
        enw(6'b000010);
        cfg(2, 3, 0);
        ev(0);
        chk("R11 src taken while locked", int'(sync_out), 0);
        ev(2);
        chk("R11 new src fires", int'(sync_out), 1);
        tick(20);
        enw(0);
        tick(10);

        // R9: write patterns
        phase = "R9";
        enw(6'b101010);
        chk("R9 pattern a", int'(cnt_en), 6'b101010);
        tick(8);
        enw(6'b010101);
        chk("R9 pattern b", int'(cnt_en), 6'b010101);
        tick(8);
        enw(0);
        chk("R9 clear", int'(cnt_en), 0);
        tick(10);

        // R10: guard window, boundary 7 vs 8 cycles
        phase = "R10";
        enw(6'b000010);
        tick(2);
        enw(6'b001000);
        chk("R10 early change refused, other bit taken", int'(cnt_en), 6'b001010);
        tick(3);
        enw(6'b001000);
        chk("R10 seven cycles refused", int'(cnt_en), 6'b001010);
        enw(6'b001000);
        chk("R10 eight cycles accepted", int'(cnt_en), 6'b001000);
        tick(10);
        enw(0);
        tick(10);

        // R7: sync input starts master, each strobe restarts
        phase = "R7";
        cfg(0, 2, 1);
        pulse_sync();
        chk("R7 restart", int'(mst_restart), 1);
        chk("R7 master enabled", int'(cnt_en[0]), 1);
        tick(1);
        chk("R7 single strobe", int'(mst_restart), 0);
        pulse_sync();
        chk("R7 restart again", int'(mst_restart), 1);
        pulse_sync();
        chk("R7 back-to-back restart", int'(mst_restart), 1);
        tick(1);
        chk("R7 no queued restart", int'(mst_restart), 0);

        // R8: sync input ignored when start-on-sync is clear
        phase = "R8";
        cfg(0, 2, 0);
        tick(10);
        enw(0);
        chk("R8 master cleared", int'(cnt_en), 0);
        tick(9);
        pulse_sync();
        chk("R8 no restart", int'(mst_restart), 0);
        chk("R8 master stays off", int'(cnt_en[0]), 0);

        tick(5);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule